// File: doc/BRIEF.md
# ALU Instruction Word Decoder

This block is the decode stage for the arithmetic and logic group of an 8-bit microcontroller core. It takes a 16-bit instruction word and produces an operation code, a 5-bit destination register index, a 5-bit source register index, an 8-bit immediate, and two strobes. One strobe allows a flag update and the other allows a register write-back.

The register indices are spread across the word. In the two-register forms, the top bit of each index sits apart from its low nibble. The immediate forms and the signed multiplies only reach part of the register file, so the decoder adds the fixed upper bits that those forms leave out of the word.

All outputs are registered in a single stage. A word that matches none of the supported encodings produces a result with the `unsupported` flag set and every strobe clear.

Top module: `aludec_stage`

## Requirements
- R1: For a two-register word the destination index is `{instr[8], instr[7:4]}` and the source index is `{instr[9], instr[3:0]}`.
- R2: The prefix in `instr[15:10]` selects the operation as follows: 000011 gives ADD (0), 000111 gives ADC (1), 000110 gives SUB (2), 000010 gives SBC (3), 001000 gives AND (4), 001010 gives OR (5), 001001 gives XOR (6), 000101 gives CP (7), 000001 gives CPC (8), and 100111 gives MUL (9).
- R3: CP, CPC and compare-immediate set `flag_we`=1 and `reg_we`=0. Every other supported word sets both strobes to 1.
- R4: A word of the form `1001010d dddd nnnn` decodes with destination `{instr[8], instr[7:4]}` and source 0. The low nibble selects the operation: 0000 gives COM (12), 0001 gives NEG (13), 1010 gives DEC (14), and 1011 gives INC (15). Any other low nibble is unsupported.
- R5: A word `0011 KKKK dddd KKKK` decodes as CP with `imm = {instr[11:8], instr[3:0]}`, `imm_used`=1, destination 16+`instr[7:4]`, and source 0.
- R6: A word `0111 wwww dddd wwww` decodes as AND with `imm = {instr[11:8], instr[3:0]}`, which is the AND operand equal to 0xFF minus the cleared-bit mask. It also sets `imm_used`=1, destination 16+`instr[7:4]`, and source 0.
- R7: A word `0x02` in `instr[15:8]` decodes as MULS (10) with destination 16+`instr[7:4]` and source 16+`instr[3:0]`.
- R8: A word with `0x03` in `instr[15:8]` and `instr[7]`=`instr[3]`=0 decodes as MULSU (11) with destination 16+`instr[6:4]` and source 16+`instr[2:0]`. If either of those two bits is 1, the word is unsupported.
- R9: An unsupported word gives `unsupported`=1 with op 0, both indices 0, imm 0, `imm_used`=0, and both strobes 0.
- R10: A word presented with `in_valid`=1 appears on the outputs one clock later with `out_valid`=1. When `in_valid`=0, `out_valid` drops and all result fields hold their previous values.
- R11: `imm_used` is 1 only for R5 and R6. For every other word, imm is 0.
- R12: A word that ANDs a register with itself (the test-for-zero idiom) decodes as a plain AND with equal source and destination indices.
- R13: While `rst_n` is low, `out_valid`, `unsupported`, both strobes and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| op | output | 4 | Operation code (R2, R4, R7, R8) |
| rd | output | 5 | Destination register index |
| rs | output | 5 | Source register index |
| imm | output | 8 | Immediate operand |
| imm_used | output | 1 | Immediate replaces source register |
| flag_we | output | 1 | Flag update enable |
| reg_we | output | 1 | Register write-back enable |
| unsupported | output | 1 | Word matched no supported form |

## Verification
Two events can fall in the same clock edge. The first is a new word being captured while the previous result is still on the outputs. The second is the hold of that result when the slot is empty.

The bench provokes this by sending back-to-back words that alternate between format groups, for example an unsupported word directly after an immediate form, and then inserting a bubble. It judges every field after each edge. After the bubble, the fields must still show the last decoded word rather than a mix of the two words.

Separately, the four format decoders must never claim the same word. This is checked on every valid cycle.

// File: rtl/aludec_pkg.sv
package aludec_pkg;

  localparam int IW      = 16;
  localparam int RIDX_W  = 5;
  localparam int DW      = 8;
  localparam int OPW     = 4;
  localparam int NSRC    = 4;
  localparam int NIB     = 4;
  localparam int UPPER_BASE = 16;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_CP    = 4'd7,
    OP_CPC   = 4'd8,
    OP_MUL   = 4'd9,
    OP_MULS  = 4'd10,
    OP_MULSU = 4'd11,
    OP_COM   = 4'd12,
    OP_NEG   = 4'd13,
    OP_DEC   = 4'd14,
    OP_INC   = 4'd15
  } op_e;

  typedef struct packed {
    logic              hit;
    op_e               op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [DW-1:0]     imm;
    logic              imm_used;
    logic              flag_we;
    logic              reg_we;
  } dec_t;

  // Joins a split-out top bit with the low nibble of an index.
  function automatic logic [RIDX_W-1:0] join_idx(input logic top, input logic [NIB-1:0] low);
    return {top, low};
  endfunction

  // Index into the upper bank (16..31) from a 4-bit field.
  function automatic logic [RIDX_W-1:0] upper_idx(input logic [NIB-1:0] f);
    return RIDX_W'(UPPER_BASE) + RIDX_W'(f);
  endfunction

  // Index into 16..23 from a 3-bit field.
  function automatic logic [RIDX_W-1:0] upper8_idx(input logic [2:0] f);
    return RIDX_W'(UPPER_BASE) + RIDX_W'(f);
  endfunction

  // Rebuilds an 8-bit constant from two nibbles.
  function automatic logic [DW-1:0] join_imm(input logic [NIB-1:0] hi, input logic [NIB-1:0] lo);
    return {hi, lo};
  endfunction

  // Compare operations only update flags.
  function automatic logic writes_back(input op_e o);
    return !(o == OP_CP || o == OP_CPC);
  endfunction

endpackage

// File: rtl/aludec_pair.sv
module aludec_pair
  import aludec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          res
);
  logic [5:0] prefix;
  logic       known;
  op_e        sel;

  assign prefix = instr[IW-1:IW-6];

  always_comb begin
    known = 1'b1;
    sel   = OP_ADD;
    case (prefix)
      6'b000011: sel = OP_ADD;
      6'b000111: sel = OP_ADC;
      6'b000110: sel = OP_SUB;
      6'b000010: sel = OP_SBC;
      6'b001000: sel = OP_AND;
      6'b001010: sel = OP_OR;
      6'b001001: sel = OP_XOR;
      6'b000101: sel = OP_CP;
      6'b000001: sel = OP_CPC;
      6'b100111: sel = OP_MUL;
      default:   known = 1'b0;
    endcase
  end

  always_comb begin
    res          = '0;
    res.hit      = known;
    res.op       = sel;
    res.rd       = join_idx(instr[8], instr[7:4]);
    res.rs       = join_idx(instr[9], instr[3:0]);
    res.flag_we  = 1'b1;
    res.reg_we   = writes_back(sel);
  end
endmodule

// File: rtl/aludec_single.sv
module aludec_single
  import aludec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          res
);
  logic group_ok;
  logic known;
  op_e  sel;

  assign group_ok = (instr[IW-1:9] == 7'b1001010);

  always_comb begin
    known = 1'b1;
    sel   = OP_COM;
    case (instr[3:0])
      4'b0000: sel = OP_COM;
      4'b0001: sel = OP_NEG;
      4'b1010: sel = OP_DEC;
      4'b1011: sel = OP_INC;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    res         = '0;
    res.hit     = group_ok && known;
    res.op      = sel;
    res.rd      = join_idx(instr[8], instr[7:4]);
    res.flag_we = 1'b1;
    res.reg_we  = 1'b1;
  end
endmodule

// File: rtl/aludec_imm.sv
module aludec_imm
  import aludec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          res
);
  logic is_cmp;
  logic is_clr;

  assign is_cmp = (instr[15:12] == 4'b0011);
  assign is_clr = (instr[15:12] == 4'b0111);

  always_comb begin
    res          = '0;
    res.hit      = is_cmp || is_clr;
    res.op       = is_cmp ? OP_CP : OP_AND;
    res.rd       = upper_idx(instr[7:4]);
    res.imm      = join_imm(instr[11:8], instr[3:0]);
    res.imm_used = 1'b1;
    res.flag_we  = 1'b1;
    res.reg_we   = !is_cmp;
  end
endmodule

// File: rtl/aludec_mul.sv
module aludec_mul
  import aludec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          res
);
  logic is_ss;
  logic is_su;

  assign is_ss = (instr[15:8] == 8'h02);
  assign is_su = (instr[15:8] == 8'h03) && !instr[7] && !instr[3];

  always_comb begin
    res         = '0;
    res.hit     = is_ss || is_su;
    res.flag_we = 1'b1;
    res.reg_we  = 1'b1;
    if (is_su) begin
      res.op = OP_MULSU;
      res.rd = upper8_idx(instr[6:4]);
      res.rs = upper8_idx(instr[2:0]);
    end else begin
      res.op = OP_MULS;
      res.rd = upper_idx(instr[7:4]);
      res.rs = upper_idx(instr[3:0]);
    end
  end
endmodule

// File: rtl/aludec_stage.sv
module aludec_stage
  import aludec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IW-1:0]     instr,
  output logic              out_valid,
  output logic [OPW-1:0]    op,
  output logic [RIDX_W-1:0] rd,
  output logic [RIDX_W-1:0] rs,
  output logic [DW-1:0]     imm,
  output logic              imm_used,
  output logic              flag_we,
  output logic              reg_we,
  output logic              unsupported
);
  dec_t            src [NSRC];
  dec_t            merged;
  logic [NSRC-1:0] hits;
  logic            no_match;

  aludec_pair   u_pair   (.instr(instr), .res(src[0]));
  aludec_single u_single (.instr(instr), .res(src[1]));
  aludec_imm    u_imm    (.instr(instr), .res(src[2]));
  aludec_mul    u_mul    (.instr(instr), .res(src[3]));

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_hit
      assign hits[g] = src[g].hit;
    end
  endgenerate

  // Format groups are disjoint, so masked OR merges them.
  always_comb begin
    merged = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src[i].hit) merged = dec_t'(merged | src[i]);
    end
  end

  assign no_match = (hits == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      op          <= '0;
      rd          <= '0;
      rs          <= '0;
      imm         <= '0;
      imm_used    <= 1'b0;
      flag_we     <= 1'b0;
      reg_we      <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op          <= merged.op;
        rd          <= merged.rd;
        rs          <= merged.rs;
        imm         <= merged.imm;
        imm_used    <= merged.imm_used;
        flag_we     <= merged.flag_we;
        reg_we      <= merged.reg_we;
        unsupported <= no_match;
      end
    end
  end
endmodule

// File: rtl/aludec_stage_chk.sv
module aludec_stage_chk
  import aludec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [OPW-1:0]    op,
  input logic [RIDX_W-1:0] rd,
  input logic [RIDX_W-1:0] rs,
  input logic [DW-1:0]     imm,
  input logic              imm_used,
  input logic              flag_we,
  input logic              reg_we,
  input logic              unsupported,
  input logic [NSRC-1:0]   hits
);
  // R9
  no_claim_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(hits));

  // R9
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (!flag_we && !reg_we && !imm_used && op == '0));

  // R3
  wb_needs_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> flag_we);

  // R11
  imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_used |-> imm == '0);

  // R6
  imm_upper_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_used |-> rd[RIDX_W-1]);

  // R8
  mulsu_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !unsupported && op == OP_MULSU) |-> (rd[4:3] == 2'b10 && rs[4:3] == 2'b10));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(op) && $stable(rd) && $stable(rs) && $stable(imm)));
endmodule

bind aludec_stage aludec_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .op(op), .rd(rd), .rs(rs), .imm(imm), .imm_used(imm_used),
  .flag_we(flag_we), .reg_we(reg_we), .unsupported(unsupported), .hits(hits)
);

// File: tb/aludec_stage_test.sv
`timescale 1ns/1ps
module aludec_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        out_valid;
  logic [3:0]  op;
  logic [4:0]  rd, rs;
  logic [7:0]  imm;
  logic        imm_used, flag_we, reg_we, unsupported;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aludec_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .op(op), .rd(rd), .rs(rs), .imm(imm),
    .imm_used(imm_used), .flag_we(flag_we), .reg_we(reg_we),
    .unsupported(unsupported)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic expect_all(input string req, input int eop, input int erd, input int ers,
                            input int eimm, input bit eiu, input bit efw, input bit erw, input bit eun);
    chk(req, "valid", 32'(out_valid), 1);
    chk(req, "op", 32'(op), 32'(eop));
    chk(req, "rd", 32'(rd), 32'(erd));
    chk(req, "rs", 32'(rs), 32'(ers));
    chk(req, "imm", 32'(imm), 32'(eimm));
    chk(req, "imm_used", 32'(imm_used), 32'(eiu));
    chk(req, "flag_we", 32'(flag_we), 32'(efw));
    chk(req, "reg_we", 32'(reg_we), 32'(erw));
    chk(req, "unsupported", 32'(unsupported), 32'(eun));
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] w_two(input logic [5:0] p, input logic [4:0] d, input logic [4:0] r);
    return {p, r[4], d[4], d[3:0], r[3:0]};
  endfunction

  task automatic t_reset();
    // R13
    chk("R13", "valid", 32'(out_valid), 0);
    chk("R13", "unsupported", 32'(unsupported), 0);
    chk("R13", "strobes", 32'({flag_we, reg_we, imm_used}), 0);
    chk("R13", "fields", 32'({op, rd, rs, imm}), 0);
  endtask

  task automatic t_two_reg();
    logic [5:0] pre [10] = '{6'b000011, 6'b000111, 6'b000110, 6'b000010, 6'b001000,
                              6'b001010, 6'b001001, 6'b000101, 6'b000001, 6'b100111};
    int dsel [3] = '{31, 0, 17};
    int ssel [3] = '{0, 31, 14};
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 3; j++) begin
        bit cmp = (i == 7) || (i == 8);
        apply(w_two(pre[i], 5'(dsel[j]), 5'(ssel[j])));
        // R1 R2 R3
        expect_all("R1/R2/R3", i, dsel[j], ssel[j], 0, 0, 1, !cmp, 0);
      end
    end
  endtask

  task automatic t_single();
    logic [3:0] nib [4] = '{4'b0000, 4'b0001, 4'b1010, 4'b1011};
    for (int i = 0; i < 4; i++) begin
      apply({7'b1001010, 1'b1, 4'h3, nib[i]});
      // R4
      expect_all("R4", 12 + i, 19, 0, 0, 0, 1, 1, 0);
    end
    apply({7'b1001010, 1'b0, 4'h5, 4'b0010});
    expect_all("R4", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_cpi();
    apply({4'b0011, 4'hA, 4'h0, 4'h5});
    // R5
    expect_all("R5", 7, 16, 0, 8'hA5, 1, 1, 0, 0);
    apply({4'b0011, 4'hF, 4'hF, 4'hF});
    expect_all("R5", 7, 31, 0, 8'hFF, 1, 1, 0, 0);
  endtask

  task automatic t_cbr();
    logic [7:0] k = 8'h03;
    logic [7:0] w = 8'hFF - k;
    apply({4'b0111, w[7:4], 4'h4, w[3:0]});
    // R6
    expect_all("R6", 4, 20, 0, 8'hFC, 1, 1, 1, 0);
  endtask

  task automatic t_mul();
    apply({8'h02, 4'hF, 4'h0});
    // R7
    expect_all("R7", 10, 31, 16, 0, 0, 1, 1, 0);
    apply({8'h03, 1'b0, 3'd7, 1'b0, 3'd2});
    // R8
    expect_all("R8", 11, 23, 18, 0, 0, 1, 1, 0);
    apply({8'h03, 1'b1, 3'd7, 1'b0, 3'd2});
    expect_all("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    apply({8'h03, 1'b0, 3'd1, 1'b1, 3'd2});
    expect_all("R8", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_unsup();
    apply(16'hFFFF);
    // R9
    expect_all("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    apply(16'h0000);
    expect_all("R9", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_tst();
    apply(w_two(6'b001000, 5'd22, 5'd22));
    // R12
    expect_all("R12", 4, 22, 22, 0, 0, 1, 1, 0);
  endtask

  task automatic t_overlap_bubble();
    // R10: back-to-back immediate then unsupported, then bubble holds
    @(negedge clk);
    instr = {4'b0011, 4'h1, 4'h2, 4'h3};
    in_valid = 1'b1;
    @(negedge clk);
    expect_all("R10", 7, 18, 0, 8'h13, 1, 1, 0, 0);
    instr = 16'hFFFF;
    @(negedge clk);
    expect_all("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    instr = w_two(6'b000011, 5'd9, 5'd10);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "valid after bubble", 32'(out_valid), 0);
    chk("R10", "held unsupported", 32'(unsupported), 1);
    chk("R10", "held rd", 32'(rd), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_two_reg();
    t_single();
    t_cpi();
    t_cbr();
    t_mul();
    t_unsup();
    t_tst();
    t_overlap_bubble();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule